// File: doc/BRIEF.md
# Quad DAC serial command receiver

This block is the digital front end of a four-channel 10-bit serial DAC. A host sends 16-bit frames over a three-wire link: an active-low frame select, a serial clock and a data line. The block samples one data bit on each falling edge of the serial clock while the frame select is low. It decodes a channel address, an operation code and a 10-bit code word, and it keeps a pair of registers for each channel. One is a staged input register. The other is an output register that drives the analog side.

The block has one system clock. The three serial lines pass through a synchronizer, and the serial clock is edge-detected in the system clock domain. The host must therefore keep each serial clock phase longer than a few system clock periods. A frame is acted on only when its sixteenth falling edge arrives. Releasing the frame select early throws the frame away. Operation code 3 switches all channels into power-down. In that state the address field selects how the analog outputs are terminated, and the channel codes are retained.

Top module: `qdac_cmd_rx`

## Requirements
- R1: Frame bits are taken MSB first on serial clock falling edges while `sync_ni` is low: address [15:14], opcode [13:12], code [11:2], bits [1:0] ignored.
- R2: A frame takes effect only on its 16th falling edge. The outputs change on the 4th rising edge of `clk_i` after that falling edge (SYNC_STAGES + 2) and are unchanged at the rising edge before it.
- R3: If `sync_ni` rises before the 16th falling edge, the frame is dropped: `code_o`, `pdown_o` and `term_o` keep their values.
- R4: Reset (`rst_ni` low) clears every channel code to 0, clears `pdown_o` and sets `term_o` to 00.
- R5: Opcode 00 loads the addressed channel's input register and leaves `code_o` unchanged.
- R6: Opcode 01 loads the addressed channel and copies all four input registers to their outputs, so codes staged earlier with opcode 00 appear together with it.
- R7: Opcode 10 writes the code to all four channels and updates all four outputs at once, whatever the address.
- R8: Opcode 11 sets `pdown_o` for any address and leaves every channel code unchanged.
- R9: `term_o` is 00 (high impedance) for power-down address 00 or 11, 01 (2.5 kΩ to ground) for address 01 and 10 (100 kΩ to ground) for address 10. It reads 00 whenever `pdown_o` is low.
- R10: Any complete frame with an opcode other than 11 clears `pdown_o` and applies that frame's own register action.
- R11: Falling edges after the 16th are ignored until `sync_ni` goes high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_ni | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock, data taken on its falling edge |
| din_i | input | 1 | Serial data |
| code_o | output | 40 | Channel output codes, channel n at [10n+9:10n] |
| pdown_o | output | 1 | Global power-down |
| term_o | output | 2 | Termination select while powered down |

## Verification
Every result of a frame is due on the fourth rising clock edge after the 16th serial clock falling edge: two synchronizer edges, one edge for the bit capture and one for the register update. The stimulus table sends each frame and then waits many clock cycles before it samples the outputs, so the checks are not sensitive to that latency. A directed test pins the latency itself. It samples on falling clock edges and confirms that the old codes are still present after three rising edges and that the new code is present after the fourth. Aborted and over-long frames are checked through the outputs they could have disturbed.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_WRUPD = 2'b01,
    OP_BCAST = 2'b10,
    OP_PDOWN = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    TERM_HIZ   = 2'b00,
    TERM_R2K5  = 2'b01,
    TERM_R100K = 2'b10
  } term_e;

  function automatic term_e term_of(logic [1:0] sel);
    case (sel)
      2'b01:   return TERM_R2K5;
      2'b10:   return TERM_R100K;
      default: return TERM_HIZ;
    endcase
  endfunction

endpackage

// File: rtl/qdac_in_sync.sv
module qdac_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx #(
  parameter int FRAME_W = 16,
  parameter int KEEP_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              done_o,
  output logic [KEEP_W-1:0] word_o
);

  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int PAD_W = FRAME_W - KEEP_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic               sclk_q;
  logic               fall;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-2:0] sh_q;
  logic [FRAME_W-1:0] sh_nxt;

  assign fall   = sclk_q & ~sclk_i;
  assign sh_nxt = {sh_q, din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      cnt_q  <= '0;
      sh_q   <= '0;
      done_o <= 1'b0;
      word_o <= '0;
    end else begin
      sclk_q <= sclk_i;
      done_o <= 1'b0;
      if (sync_n_i) begin
        cnt_q <= '0;                       // frame closed or aborted
      end else if (fall && cnt_q != FULL) begin
        sh_q  <= sh_nxt[FRAME_W-2:0];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          done_o <= 1'b1;
          word_o <= sh_nxt[FRAME_W-1:PAD_W];
        end
      end
    end
  end

endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 10,
  parameter int ADDR_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     done_i,
  input  op_e                      op_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [NUM_CH*DATA_W-1:0] code_o
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [DATA_W-1:0] in_q, out_q;
    logic              hit;

    assign hit = (addr_i == ADDR_W'(ch));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q  <= '0;
        out_q <= '0;
      end else if (done_i) begin
        case (op_i)
          OP_LOAD:  if (hit) in_q <= data_i;
          OP_WRUPD: begin
            if (hit) begin
              in_q  <= data_i;
              out_q <= data_i;
            end else begin
              out_q <= in_q;               // staged codes go out together
            end
          end
          OP_BCAST: begin
            in_q  <= data_i;
            out_q <= data_i;
          end
          default: ;                       // power-down keeps codes
        endcase
      end
    end

    assign code_o[ch*DATA_W +: DATA_W] = out_q;
  end

endmodule

// File: rtl/qdac_pwr_ctl.sv
module qdac_pwr_ctl
  import qdac_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  op_e        op_i,
  input  logic [1:0] sel_i,
  output logic       pdown_o,
  output term_e      term_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdown_o <= 1'b0;
      term_o  <= TERM_HIZ;
    end else if (done_i) begin
      if (op_i == OP_PDOWN) begin
        pdown_o <= 1'b1;
        term_o  <= term_of(sel_i);
      end else begin
        pdown_o <= 1'b0;
        term_o  <= TERM_HIZ;
      end
    end
  end

endmodule

// File: rtl/qdac_cmd_rx.sv
module qdac_cmd_rx
  import qdac_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 10,
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sync_ni,
  input  logic                     sclk_i,
  input  logic                     din_i,
  output logic [NUM_CH*DATA_W-1:0] code_o,
  output logic                     pdown_o,
  output logic [1:0]               term_o
);

  localparam int ADDR_W = $clog2(NUM_CH);
  localparam int OP_W   = 2;
  localparam int KEEP_W = ADDR_W + OP_W + DATA_W;

  logic              sync_s, sclk_s, din_s;
  logic              frame_done;
  logic [KEEP_W-1:0] frame_word;
  logic [ADDR_W-1:0] frame_addr;
  op_e               frame_op;
  logic [DATA_W-1:0] frame_data;
  term_e             term_q;

  qdac_in_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sync_ni, sclk_i, din_i}),
    .q_o   ({sync_s, sclk_s, din_s})
  );

  qdac_frame_rx #(
    .FRAME_W(FRAME_W),
    .KEEP_W (KEEP_W)
  ) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_n_i(sync_s),
    .sclk_i  (sclk_s),
    .din_i   (din_s),
    .done_o  (frame_done),
    .word_o  (frame_word)
  );

  assign frame_addr = frame_word[KEEP_W-1 -: ADDR_W];
  assign frame_op   = op_e'(frame_word[DATA_W +: OP_W]);
  assign frame_data = frame_word[DATA_W-1:0];

  qdac_chan_bank #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(frame_done),
    .op_i  (frame_op),
    .addr_i(frame_addr),
    .data_i(frame_data),
    .code_o(code_o)
  );

  qdac_pwr_ctl u_pwr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (frame_done),
    .op_i   (frame_op),
    .sel_i  (frame_addr[1:0]),
    .pdown_o(pdown_o),
    .term_o (term_q)
  );

  assign term_o = term_q;

endmodule

// File: rtl/qdac_cmd_rx_chk.sv
module qdac_cmd_rx_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 10,
  parameter int ADDR_W = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     frame_done,
  input logic [1:0]               frame_op,
  input logic [ADDR_W-1:0]        frame_addr,
  input logic [DATA_W-1:0]        frame_data,
  input logic [NUM_CH*DATA_W-1:0] code_o,
  input logic                     pdown_o,
  input logic [1:0]               term_o
);

  AST_TERM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdown_o |-> term_o == 2'b00);                                            // R9

  AST_NO_FRAME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done |=> $stable(code_o) && $stable(pdown_o) && $stable(term_o));  // R2

  AST_LOAD_NO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && frame_op == 2'b00 |=> $stable(code_o));                     // R5

  AST_BCAST_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && frame_op == 2'b10 |=> code_o == {NUM_CH{$past(frame_data)}}); // R7

  AST_PD_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && frame_op == 2'b11 |=> pdown_o && $stable(code_o));          // R8

  AST_PD_TERM_2K5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && frame_op == 2'b11 && frame_addr[1:0] == 2'b01 |=> term_o == 2'b01); // R9

  AST_PD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && frame_op != 2'b11 |=> !pdown_o);                            // R10

endmodule

bind qdac_cmd_rx qdac_cmd_rx_chk #(
  .NUM_CH(NUM_CH),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frame_done(frame_done),
  .frame_op  (frame_op),
  .frame_addr(frame_addr),
  .frame_data(frame_data),
  .code_o    (code_o),
  .pdown_o   (pdown_o),
  .term_o    (term_o)
);

// File: tb/qdac_cmd_rx_tb.sv
module qdac_cmd_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;   // system clocks per serial clock phase
  localparam int LAT        = 4;   // SYNC_STAGES + 2
  localparam int NV         = 12;

  // {frame[15:0], nbits[4:0], code[39:0] ch3..ch0, pdown, term[1:0]}
  localparam logic [63:0] VECS [NV] = '{
    {2'd1, 2'b01, 10'h155, 2'b00, 5'd16, 10'h000, 10'h000, 10'h155, 10'h000, 1'b0, 2'b00}, // R6
    {2'd2, 2'b00, 10'h2AA, 2'b00, 5'd16, 10'h000, 10'h000, 10'h155, 10'h000, 1'b0, 2'b00}, // R5
    {2'd0, 2'b01, 10'h3FF, 2'b00, 5'd16, 10'h000, 10'h2AA, 10'h155, 10'h3FF, 1'b0, 2'b00}, // R6
    {2'd3, 2'b01, 10'h111, 2'b00, 5'd10, 10'h000, 10'h2AA, 10'h155, 10'h3FF, 1'b0, 2'b00}, // R3
    {2'd1, 2'b11, 10'h000, 2'b00, 5'd16, 10'h000, 10'h2AA, 10'h155, 10'h3FF, 1'b1, 2'b01}, // R8
    {2'd2, 2'b11, 10'h3FF, 2'b00, 5'd16, 10'h000, 10'h2AA, 10'h155, 10'h3FF, 1'b1, 2'b10}, // R9
    {2'd3, 2'b11, 10'h000, 2'b00, 5'd16, 10'h000, 10'h2AA, 10'h155, 10'h3FF, 1'b1, 2'b00}, // R9
    {2'd3, 2'b00, 10'h0AB, 2'b00, 5'd16, 10'h000, 10'h2AA, 10'h155, 10'h3FF, 1'b0, 2'b00}, // R10
    {2'd0, 2'b11, 10'h000, 2'b00, 5'd16, 10'h000, 10'h2AA, 10'h155, 10'h3FF, 1'b1, 2'b00}, // R8
    {2'd1, 2'b10, 10'h200, 2'b00, 5'd16, 10'h200, 10'h200, 10'h200, 10'h200, 1'b0, 2'b00}, // R7
    {2'd3, 2'b01, 10'h001, 2'b11, 5'd16, 10'h001, 10'h200, 10'h200, 10'h200, 1'b0, 2'b00}, // R1
    {2'd0, 2'b11, 10'h000, 2'b00, 5'd15, 10'h001, 10'h200, 10'h200, 10'h200, 1'b0, 2'b00}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_ni = 1'b1;
  logic        sclk_i = 1'b1;
  logic        din_i = 1'b0;
  logic [39:0] code_o;
  logic        pdown_o;
  logic [1:0]  term_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdac_cmd_rx u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .sync_ni(sync_ni),
    .sclk_i (sclk_i),
    .din_i  (din_i),
    .code_o (code_o),
    .pdown_o(pdown_o),
    .term_o (term_o)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_fall(input logic b);
    din_i = b;
    wait_clk(HALF);
    sclk_i = 1'b0;
  endtask

  task automatic bit_rise();
    wait_clk(HALF);
    sclk_i = 1'b1;
  endtask

  task automatic send_frame(input logic [15:0] w, input int nbits, input int extra);
    sync_ni = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits + extra; i++) begin
      bit_fall(i < 16 ? w[15-i] : 1'b1);
      bit_rise();
    end
    wait_clk(HALF);
    sync_ni = 1'b1;
    wait_clk(3 * LAT);
  endtask

  initial begin
    wait_clk(3);
    // R4: state under reset
    check("R4", "code in reset", 64'(code_o), 64'h0);
    check("R4", "pdown in reset", 64'(pdown_o), 64'h0);
    rst_ni = 1'b1;
    wait_clk(3);
    check("R4", "code after reset", 64'(code_o), 64'h0);
    check("R4", "term after reset", 64'(term_o), 64'h0);

    for (int v = 0; v < NV; v++) begin
      send_frame(VECS[v][63:48], int'(VECS[v][47:43]), 0);
      check($sformatf("R1 vec%0d", v), "code", 64'(code_o), 64'(VECS[v][42:3]));
      check($sformatf("R8 vec%0d", v), "pdown", 64'(pdown_o), 64'(VECS[v][2]));
      check($sformatf("R9 vec%0d", v), "term", 64'(term_o), 64'(VECS[v][1:0]));
    end

    // R11: 16 extra falling edges of ones would form a power-down frame
    send_frame({2'd2, 2'b01, 10'h07F, 2'b00}, 16, 16);
    check("R11", "code ch2", 64'(code_o[29:20]), 64'h07F);
    check("R11", "pdown", 64'(pdown_o), 64'h0);

    // R4: asynchronous reset mid-operation
    rst_ni = 1'b0;
    wait_clk(2);
    check("R4", "code on reset", 64'(code_o), 64'h0);
    rst_ni = 1'b1;
    wait_clk(3);

    // R2: update lands on the LAT-th clock edge after the 16th fall
    begin
      logic [15:0] w;
      w = {2'd0, 2'b01, 10'h0F0, 2'b00};
      sync_ni = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < 15; i++) begin
        bit_fall(w[15-i]);
        bit_rise();
      end
      bit_fall(w[0]);
      wait_clk(LAT - 1);
      check("R2", "code before latency", 64'(code_o), 64'h0);
      wait_clk(1);
      check("R2", "code at latency", 64'(code_o), 64'h0F0);
      bit_rise();
      wait_clk(HALF);
      sync_ni = 1'b1;
      wait_clk(3 * LAT);
    end

    // R5: a load after reset stays staged until a write-update
    send_frame({2'd1, 2'b00, 10'h0C3, 2'b00}, 16, 0);
    check("R5", "staged only", 64'(code_o), 64'h0F0);
    send_frame({2'd3, 2'b01, 10'h005, 2'b00}, 16, 0);
    check("R6", "staged released", 64'(code_o),
          64'({10'h005, 10'h000, 10'h0C3, 10'h0F0}));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule